// File: doc/BRIEF.md
# Dual-Clock FIFO with Cross-Domain Status

This block moves words from a producer on one clock to a consumer on an unrelated clock. Each side has its own full, empty and occupancy outputs. Every status output changes after a fixed number of edges of its own clock, plus a fixed number of edges of the other clock when the event started on the far side. Write and read pointers cross between the domains as Gray code. Each crossing passes through a chain of `SYNC_STAGES` flip-flops. A status flag can therefore lag the true state, but it never reports room or data that does not exist.

Back-pressure works as follows. The producer holds `wr_valid` with `wr_data`. A word is taken on a write-clock edge where both `wr_valid` and `wr_ready` are high, and `wr_ready` is simply `wr_full` inverted. The consumer raises `rd_ready` to take a word. A pop happens on a read-clock edge only while `rd_empty` is low, and a request made while the FIFO is empty is ignored. The `SHOW_AHEAD` parameter selects the read mode. In normal mode, a pop loads the popped word into `rd_data`. In show-ahead mode, the head word is already on `rd_data` whenever `rd_empty` is low, and a pop moves the next word there.

Top module: `xclk_fifo`

## Requirements
- R1: While `arst_n` is low and right after it rises, both empty flags are 1, both full flags are 0, both used counts are 0 and `rd_data` is 0.
- R2: After a write-clock edge that accepts a word, `wr_full` and `wr_empty` show the new state after that edge. `wr_used` shows it one write-clock edge later.
- R3: The write pointer is re-registered on the next write-clock edge and then crosses `SYNC_STAGES` read-clock flops. `rd_empty` and `rd_full` react after the `SYNC_STAGES`-th read-clock edge that follows that second write edge. `rd_used` reacts one read-clock edge later.
- R4: After a read-clock edge that pops a word, `rd_empty` and `rd_full` show the new state after that edge. `rd_used` shows it one read-clock edge later.
- R5: After a popping read-clock edge, `wr_full` and `wr_empty` react after the `SYNC_STAGES`-th following write-clock edge. `wr_used` reacts one write-clock edge after that.
- R6: In normal mode (`SHOW_AHEAD`=0), the popped word is on `rd_data` after the popping read-clock edge.
- R7: In show-ahead mode (`SHOW_AHEAD`=1), a word written into an empty FIFO is on `rd_data` after the first read-clock edge following the write edge. Whenever `rd_empty` is 0, `rd_data` holds the oldest unread word.
- R8: `wr_ready` equals `wr_full` inverted. A write offered while the FIFO is full, or a read requested while it is empty, changes no pointer, count or stored word.
- R9: Each pointer that crosses a domain changes by at most one bit per clock of its source domain (Gray code).
- R10: Under any traffic, words leave in the order they entered, with none lost or duplicated. `wr_full`=0 implies fewer than 2^`ADDR_W` words are stored, and `rd_empty`=0 implies at least one word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can take a word (not full) |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Write-side full flag |
| wr_empty | output | 1 | Write-side empty flag |
| wr_used | output | ADDR_W+1 | Write-side occupancy (registered) |
| rd_ready | input | 1 | Consumer takes a word if one is available |
| rd_data | output | DATA_W | Output word (mode set by SHOW_AHEAD) |
| rd_empty | output | 1 | Read-side empty flag (no word available) |
| rd_full | output | 1 | Read-side full flag |
| rd_used | output | ADDR_W+1 | Read-side occupancy (registered) |

## Verification
The hardest conditions to reach are the exact edges at which a flag crosses domains. These depend on how two unrelated clocks line up. The bench runs a 125 MHz write clock against a 13 ns read clock whose edges never coincide with write edges. It then counts edges of the far clock after a single isolated write or pop, so each latency in R3 and R5 is measured against a known edge. A full FIFO and an empty FIFO are both held under continued requests to expose leaks. Random traffic at skewed rates in both directions then pushes the flags through many late-deassertion windows.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
`timescale 1ns/1ps
module xclk_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) stg[i] <= '0;
        else         stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) stg[i] <= '0;
        else         stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xclk_fifo_wr_ctl.sv
`timescale 1ns/1ps
module xclk_fifo_wr_ctl
  import xclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              arst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              wr_ready,
  output logic              wr_full,
  output logic              wr_empty,
  output logic [ADDR_W:0]   wr_used,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray
);
  localparam logic [ADDR_W:0] FULL_CNT = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] wbin, rbin_w, occ;
  logic [31:0]     rbin_wide;

  assign rbin_wide = from_gray(32'(rgray_sync));
  assign rbin_w    = rbin_wide[ADDR_W:0];
  assign occ       = wbin - rbin_w;
  assign wr_full   = (occ == FULL_CNT);
  assign wr_empty  = (occ == '0);
  assign wr_ready  = ~wr_full;
  assign wr_en     = wr_valid & ~wr_full;
  assign waddr     = wbin[ADDR_W-1:0];

  logic [31:0] wgray_wide;
  assign wgray_wide = to_gray(32'(wbin));

  always_ff @(posedge wclk or negedge arst_n) begin
    if (!arst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      wr_used <= '0;
    end else begin
      wbin    <= wbin + {{ADDR_W{1'b0}}, wr_en};
      wgray   <= wgray_wide[ADDR_W:0];
      wr_used <= occ;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!arst_n)
    wr_full |=> (wbin == $past(wbin)));
  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!arst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R10
  wused_range_chk: assert property (@(posedge wclk) disable iff (!arst_n)
    wr_used <= FULL_CNT);
endmodule

// File: rtl/xclk_fifo_rd_ctl.sv
`timescale 1ns/1ps
module xclk_fifo_rd_ctl
  import xclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              rclk,
  input  logic              arst_n,
  input  logic              rd_ready,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic              rd_empty,
  output logic              rd_full,
  output logic [ADDR_W:0]   rd_used,
  output logic              rd_pop,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W-1:0] raddr_next,
  output logic [ADDR_W:0]   rgray
);
  localparam logic [ADDR_W:0] FULL_CNT = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] rbin, rbin_next, wbin_r, occ;
  logic [31:0]     wbin_wide, rgray_wide;

  assign wbin_wide  = from_gray(32'(wgray_sync));
  assign wbin_r     = wbin_wide[ADDR_W:0];
  assign occ        = wbin_r - rbin;
  assign rd_empty   = (occ == '0);
  assign rd_full    = (occ == FULL_CNT);
  assign rd_pop     = rd_ready & ~rd_empty;
  assign rbin_next  = rbin + {{ADDR_W{1'b0}}, rd_pop};
  assign raddr      = rbin[ADDR_W-1:0];
  assign raddr_next = rbin_next[ADDR_W-1:0];
  assign rgray_wide = to_gray(32'(rbin_next));

  always_ff @(posedge rclk or negedge arst_n) begin
    if (!arst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_used <= '0;
    end else begin
      rbin    <= rbin_next;
      rgray   <= rgray_wide[ADDR_W:0];
      rd_used <= occ;
    end
  end

  // R8
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!arst_n)
    rd_empty |=> (rbin == $past(rbin)));
  // R9
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!arst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R10
  rused_range_chk: assert property (@(posedge rclk) disable iff (!arst_n)
    rd_used <= FULL_CNT);
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit SHOW_AHEAD  = 1'b0
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              arst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_empty,
  output logic [ADDR_W:0]   wr_used,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_full,
  output logic [ADDR_W:0]   rd_used
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              wr_en, rd_pop;
  logic [ADDR_W-1:0] waddr, raddr, raddr_next;
  logic [ADDR_W:0]   wgray, rgray, wgray_sync, rgray_sync;
  logic [DATA_W-1:0] mem [DEPTH];

  xclk_fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk(wclk), .arst_n(arst_n), .wr_valid(wr_valid), .rgray_sync(rgray_sync),
    .wr_ready(wr_ready), .wr_full(wr_full), .wr_empty(wr_empty),
    .wr_used(wr_used), .wr_en(wr_en), .waddr(waddr), .wgray(wgray)
  );

  xclk_fifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .rclk(rclk), .arst_n(arst_n), .rd_ready(rd_ready), .wgray_sync(wgray_sync),
    .rd_empty(rd_empty), .rd_full(rd_full), .rd_used(rd_used),
    .rd_pop(rd_pop), .raddr(raddr), .raddr_next(raddr_next), .rgray(rgray)
  );

  xclk_fifo_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .arst_n(arst_n), .d(wgray), .q(wgray_sync)
  );

  xclk_fifo_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .arst_n(arst_n), .d(rgray), .q(rgray_sync)
  );

  always_ff @(posedge wclk)
    if (wr_en) mem[waddr] <= wr_data;

  if (SHOW_AHEAD) begin : g_show_ahead
    always_ff @(posedge rclk or negedge arst_n)
      if (!arst_n) rd_data <= '0;
      else         rd_data <= mem[raddr_next];
  end else begin : g_normal
    always_ff @(posedge rclk or negedge arst_n)
      if (!arst_n)     rd_data <= '0;
      else if (rd_pop) rd_data <= mem[raddr];
  end

  initial begin
    // R9
    sync_depth_chk: assert (SYNC_STAGES >= 2);
  end
endmodule

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/1ps
module xclk_fifo_tb;
  localparam int DW = 8, AW = 4, N = 2, DEPTH = 16;

  logic wclk, rclk, arst_n, wr_valid, rd_ready;
  logic [DW-1:0] wr_data, sa_data, nm_data;
  logic wr_ready, wr_full, wr_empty, rd_empty, rd_full;
  logic wr_ready2, wr_full2, wr_empty2, rd_empty2, rd_full2;
  logic [AW:0] wr_used, rd_used, wr_used2, rd_used2;

  int tests = 0, fails = 0;
  logic [DW-1:0] q[$];
  bit pend; logic [DW-1:0] pend_val;
  bit wr_done;

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(N), .SHOW_AHEAD(1'b1)) u_dut (
    .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_full(wr_full), .wr_empty(wr_empty), .wr_used(wr_used),
    .rd_ready(rd_ready), .rd_data(sa_data), .rd_empty(rd_empty), .rd_full(rd_full),
    .rd_used(rd_used));

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(N), .SHOW_AHEAD(1'b0)) u_dut_nrm (
    .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .wr_valid(wr_valid), .wr_ready(wr_ready2),
    .wr_data(wr_data), .wr_full(wr_full2), .wr_empty(wr_empty2), .wr_used(wr_used2),
    .rd_ready(rd_ready), .rd_data(nm_data), .rd_empty(rd_empty2), .rd_full(rd_full2),
    .rd_used(rd_used2));

  initial begin wclk = 0; forever #4 wclk = ~wclk; end
  initial begin rclk = 0; forever #6.5 rclk = ~rclk; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit coin(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  // one write-domain step, called at a falling wclk edge
  task automatic wr_step(input bit want, input logic [DW-1:0] d);
    wr_valid = 0;
    if (!wr_full) chk("R10 room", 32'(q.size() < DEPTH), 1);
    if (want && !wr_full) begin
      wr_valid = 1; wr_data = d; q.push_back(d);
    end
  endtask

  // one read-domain step, called at a falling rclk edge
  task automatic rd_step(input bit want);
    if (pend) begin chk("R6 normal data", nm_data, pend_val); pend = 0; end
    rd_ready = 0;
    if (!rd_empty) begin
      chk("R10 data present", 32'(q.size() > 0), 1);
      if (q.size() > 0) begin
        chk("R7 head on output", sa_data, q[0]);
        if (want) begin rd_ready = 1; pend_val = q.pop_front(); pend = 1; end
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    arst_n = 0; wr_valid = 0; rd_ready = 0; wr_data = 0; pend = 0; wr_done = 0;
    repeat (3) @(negedge wclk);
    // R1
    chk("R1 wr_empty", wr_empty, 1); chk("R1 rd_empty", rd_empty, 1);
    chk("R1 wr_full", wr_full, 0);   chk("R1 rd_full", rd_full, 0);
    chk("R1 used", {wr_used, rd_used}, 0); chk("R1 data", {sa_data, nm_data}, 0);
    arst_n = 1;
    repeat (4) @(negedge wclk);
    chk("R1 after release", {rd_empty, wr_empty, wr_ready}, 3'b111);

    // R2/R3/R7: single write into empty FIFO
    @(negedge wclk); wr_valid = 1; wr_data = 8'h5A; q.push_back(8'h5A);
    @(posedge wclk); #0.2; wr_valid = 0;
    chk("R2 wr_empty 1 wclk", wr_empty, 0);
    chk("R2 wr_used not yet", wr_used, 0);
    fork
      begin @(posedge rclk); #0.2; chk("R7 show-ahead 1 rclk", sa_data, 8'h5A); end
      begin
        @(posedge wclk); #0.2;
        chk("R2 wr_used 2 wclk", wr_used, 1);
        repeat (N-1) @(posedge rclk);
        #0.2 chk("R3 rd_empty still set", rd_empty, 1);
        @(posedge rclk); #0.2;
        chk("R3 rd_empty after n rclk", rd_empty, 0);
        chk("R3 rd_used not yet", rd_used, 0);
        @(posedge rclk); #0.2;
        chk("R3 rd_used after n+1", rd_used, 1);
      end
    join

    // R4/R5/R6: single pop
    @(negedge rclk); rd_ready = 1; void'(q.pop_front());
    @(posedge rclk);
    fork
      begin
        #0.2 rd_ready = 0;
        chk("R4 rd_empty 1 rclk", rd_empty, 1);
        chk("R4 rd_used not yet", rd_used, 1);
        chk("R6 normal data 1 rclk", nm_data, 8'h5A);
        @(posedge rclk); #0.2 chk("R4 rd_used 2 rclk", rd_used, 0);
      end
      begin
        repeat (N-1) @(posedge wclk);
        #0.2 chk("R5 wr_empty still clear", wr_empty, 0);
        @(posedge wclk); #0.2;
        chk("R5 wr_empty after n wclk", wr_empty, 1);
        chk("R5 wr_used not yet", wr_used, 1);
        @(posedge wclk); #0.2 chk("R5 wr_used after n+1", wr_used, 0);
      end
    join

    // R8: fill, then push while full
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wclk); wr_step(1, 8'(8'h10 + i));
    end
    @(posedge wclk); #0.2; wr_valid = 0;
    chk("R2 wr_full 1 wclk", wr_full, 1);
    chk("R8 wr_ready low when full", wr_ready, 0);
    @(negedge wclk); wr_valid = 1; wr_data = 8'hEE;
    repeat (5) @(negedge wclk);
    chk("R8 full write ignored", wr_used, DEPTH);
    wr_valid = 0;
    repeat (6) @(negedge rclk);
    chk("R3 rd_full", rd_full, 1); chk("R3 rd_used full", rd_used, DEPTH);
    rd_step(1);
    @(posedge rclk); #0.2 chk("R4 rd_full clears 1 rclk", rd_full, 0);
    while (q.size() > 0) begin @(negedge rclk); rd_step(1); end
    @(negedge rclk); rd_step(0);

    // R8: pop while empty
    @(negedge rclk); rd_ready = 1;
    repeat (5) @(negedge rclk);
    chk("R8 empty read ignored", rd_used, 0);
    chk("R8 empty read data kept", nm_data, 8'h1F);
    rd_ready = 0;
    @(negedge wclk); wr_step(1, 8'hC3);
    @(negedge wclk); wr_step(0, 0);
    repeat (8) @(negedge rclk);
    rd_step(1); @(negedge rclk); rd_step(0);

    // R10: random traffic, two rate mixes
    for (int ph = 0; ph < 2; ph++) begin
      wr_done = 0;
      fork
        begin
          for (int k = 0; k < 600; k++) begin
            @(negedge wclk); wr_step(coin(ph == 0 ? 80 : 30), 8'($urandom));
          end
          @(negedge wclk); wr_step(0, 0);
          wr_done = 1;
        end
        begin
          while (!(wr_done && q.size() == 0)) begin
            @(negedge rclk); rd_step(coin(ph == 0 ? 40 : 90));
          end
          @(negedge rclk); rd_step(0);
        end
      join
    end
    repeat (10) @(negedge wclk);
    chk("R9 pointers agree at rest", {wr_used, rd_used, wr_empty, rd_empty}, {5'd0, 5'd0, 2'b11});
    chk("R10 modes agree", {wr_full2, rd_empty2, wr_used2}, {wr_full, rd_empty, wr_used});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule